// File: doc/BRIEF.md
# Serial Input Snapshot and Mask Holder

This block captures a bank of parallel input levels and makes them available over a four-wire serial link with a chip select, a serial clock, a data input and a data output. The capture happens when chip select is pulled low. The first serial clock rising edge copies the captured word into a shifter and presents its top bit. Each later rising edge moves the next bit out, most significant bit first. While the word goes out, a new word comes in from the data input. When chip select returns high, that word becomes the mask register. The status and mask registers feed a separate interrupt unit.

The serial clock, chip select and data input are asynchronous to the block. They are oversampled by a fast system clock through multi-flop synchronizers, and edges are found from the synchronized samples. The serial data output is a data bit plus a drive-enable, so a board or wrapper can build the tri-state pad. Several blocks can be chained by feeding one output into the next input, with the select and clock shared. The chain then acts as one long shift register, 16 bits per stage.

Top module: `spi_capture_mask`

## Requirements
- R1: On a chip select falling edge, the input levels are stored into the status register `status_q`. Input changes after that edge do not alter `status_q` until the next falling edge.
- R2: While chip select is low, the first serial clock rising edge loads the shifter from `status_q` and puts bit 15 on `sdo_data`. Each further rising edge presents the next lower bit.
- R3: The data input is sampled on the serial clock falling edge, and its value at the rising edge has no effect. Serial clock and data input activity while chip select is high leaves both registers unchanged.
- R4: On the chip select rising edge, `mask_q` takes the last 16 bits clocked in. The first bit received lands in bit 15. Any number of clocks may be given.
- R5: `sdo_oe` is 0 while chip select is high and 1 while chip select is low.
- R6: Committing an all-zero mask clears `status_q` to zero.
- R7: Reset (`rst`, synchronous, active high) clears `status_q` and `mask_q` to zero and disables `sdo_oe`.
- R8: With more than 16 clocks, the bits entered at the data input reappear at `sdo_data` after 16 rising edges, in the same order, so the block forms one 16-bit chain stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 16 | Parallel input levels to capture |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, low while idle |
| sdin | input | 1 | Serial data input |
| sdo_data | output | 1 | Serial data output bit |
| sdo_oe | output | 1 | Drive enable for the serial data output |
| status_q | output | 16 | Captured input status register |
| mask_q | output | 16 | Committed mask register |

## Verification
A wrong captured word shows up on `status_q` a few system clocks after the select falls. It also shows up at `sdo_data` from the first serial clock rising edge onward. A shifter that drops or duplicates a bit is not seen in the first word out. It shows up in the bits echoed after the sixteenth rising edge, and in `mask_q` once the select rises. A data input sampled on the wrong serial clock edge corrupts every committed mask bit. A missed zero-mask reset leaves a stale `status_q` visible right after the commit.

// File: rtl/scm_pkg.sv
package scm_pkg;
    localparam int unsigned SCM_WIDTH = 16;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic [SCM_WIDTH-1:0] push_lsb(input logic [SCM_WIDTH-1:0] w,
                                                      input logic b);
        return {w[SCM_WIDTH-2:0], b};
    endfunction
endpackage

// File: rtl/scm_edge_sync.sv
module scm_edge_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    output scm_pkg::edge_t  ev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
            prev_q  <= IDLE;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev.lvl  = chain_q[STAGES-1];
        ev.rise = chain_q[STAGES-1] & ~prev_q;
        ev.fall = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/scm_bus_sync.sv
module scm_bus_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scm_shifter.sv
module scm_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             start,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sdin_s,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] word_q,
    output logic [WIDTH-1:0] merged,
    output logic             first_rise
);
    logic loaded_q;
    logic pend_v_q;
    logic pend_b_q;

    assign first_rise = active & sck_rise & ~loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            loaded_q <= 1'b0;
            pend_v_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else if (start) begin
            loaded_q <= 1'b0;
            pend_v_q <= 1'b0;
        end else if (active) begin
            if (sck_rise) begin
                if (!loaded_q) begin
                    word_q   <= load_word;
                    loaded_q <= 1'b1;
                end else if (pend_v_q) begin
                    word_q <= {word_q[WIDTH-2:0], pend_b_q};
                end
                pend_v_q <= 1'b0;
            end else if (sck_fall) begin
                pend_b_q <= sdin_s;
                pend_v_q <= 1'b1;
            end
        end
    end

    always_comb begin
        merged = word_q;
        if (pend_v_q) merged = {word_q[WIDTH-2:0], pend_b_q};
    end

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(word_q));
endmodule

// File: rtl/spi_capture_mask.sv
module spi_capture_mask #(
    parameter int unsigned WIDTH       = scm_pkg::SCM_WIDTH,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_in,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdin,
    output logic             sdo_data,
    output logic             sdo_oe,
    output logic [WIDTH-1:0] status_q,
    output logic [WIDTH-1:0] mask_q
);
    import scm_pkg::*;

    edge_t            cs_ev, sck_ev, sdi_ev;
    logic [WIDTH-1:0] pins_s;
    logic [WIDTH-1:0] sh_word, sh_merged;
    logic             first_rise;
    logic             active, commit, zero_commit;

    scm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .din(cs_n), .ev(cs_ev));
    scm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .din(sclk), .ev(sck_ev));
    scm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sdi_sync (
        .clk(clk), .rst(rst), .din(sdin), .ev(sdi_ev));
    scm_bus_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst(rst), .din(pins_in), .dout(pins_s));

    assign active      = ~cs_ev.lvl;
    assign commit      = cs_ev.rise;
    assign zero_commit = commit & (sh_merged == '0);

    scm_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst(rst), .active(active), .start(cs_ev.fall),
        .sck_rise(sck_ev.rise), .sck_fall(sck_ev.fall), .sdin_s(sdi_ev.lvl),
        .load_word(status_q), .word_q(sh_word), .merged(sh_merged),
        .first_rise(first_rise));

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            if (cs_ev.fall) status_q <= pins_s;
            else if (zero_commit) status_q <= '0;
            if (commit) mask_q <= sh_merged;
        end
    end

    assign sdo_data = sh_word[WIDTH-1];
    assign sdo_oe   = active;

    p_status_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !cs_ev.fall && !commit |=> $stable(status_q));
    p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
        first_rise |=> sdo_data == $past(status_q[WIDTH-1]));
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(mask_q));
    p_zero_reset_r6: assert property (@(posedge clk) disable iff (rst)
        zero_commit |=> (status_q == '0) && (mask_q == '0));
    p_oe_idle_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> !sdo_oe);
endmodule

// File: tb/spi_capture_mask_tb.sv
module spi_capture_mask_tb;
    localparam int W  = 16;
    localparam int HP = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pins_in = '0;
    logic         cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic         sdo_data, sdo_oe;
    logic [W-1:0] status_q, mask_q;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    spi_capture_mask u_dut (
        .clk(clk), .rst(rst), .pins_in(pins_in), .cs_n(cs_n), .sclk(sclk),
        .sdin(sdin), .sdo_data(sdo_data), .sdo_oe(sdo_oe),
        .status_q(status_q), .mask_q(mask_q));

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0; wclk(HP);
    endtask

    task automatic cs_high();
        cs_n = 1'b1; wclk(HP);
    endtask

    // Sends tx[n-1] first; the data input is changed to the wrong value after each
    // falling edge so that sampling on the rising edge would be caught (R3).
    task automatic xfer(input logic [63:0] tx, input int n, output logic [63:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; wclk(HP);
            rx[n-1-i] = sdo_data;
            sdin = tx[n-1-i];
            wclk(HP);
            sclk = 1'b0; wclk(HP);
            sdin = ~tx[n-1-i];
            wclk(HP);
        end
        sdin = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 status", status_q, 0);
        chk("R7 mask", mask_q, 0);
        chk("R7 oe", sdo_oe, 0);
    endtask

    task automatic t_basic(input logic [W-1:0] pins, input logic [W-1:0] m);
        logic [63:0] rx;
        pins_in = pins; wclk(HP);
        cs_low();
        chk("R1 capture", status_q, pins);
        chk("R5 oe low", sdo_oe, 1);
        pins_in = ~pins; wclk(HP);
        chk("R1 hold", status_q, pins);
        xfer(m, 16, rx);
        chk("R2 shifted out", rx[15:0], pins);
        cs_high();
        chk("R4 mask", mask_q, m);
        chk("R5 oe high", sdo_oe, 0);
        chk("R1 after", status_q, pins);
    endtask

    task automatic t_long(input logic [W-1:0] pins);
        logic [63:0] rx, tx;
        tx = 64'h0000_0000_000C_3A5B;
        pins_in = pins; wclk(HP);
        cs_low();
        xfer(tx, 20, rx);
        cs_high();
        chk("R2 long status", rx[19:4], pins);
        chk("R8 echo", rx[3:0], tx[19:16]);
        chk("R4 last16", mask_q, tx[15:0]);
    endtask

    task automatic t_idle();
        logic [W-1:0] s0, m0;
        s0 = status_q; m0 = mask_q;
        for (int i = 0; i < 6; i++) begin
            sdin = i[0]; sclk = 1'b1; wclk(HP);
            sclk = 1'b0; wclk(HP);
        end
        sdin = 1'b0;
        chk("R3 idle mask", mask_q, m0);
        chk("R3 idle status", status_q, s0);
        chk("R5 idle oe", sdo_oe, 0);
    endtask

    task automatic t_swreset();
        logic [63:0] rx;
        pins_in = 16'hBEEF; wclk(HP);
        cs_low();
        chk("R6 pre", status_q, 16'hBEEF);
        xfer(64'h0, 16, rx);
        cs_high();
        chk("R6 status cleared", status_q, 0);
        chk("R6 mask zero", mask_q, 0);
    endtask

    task automatic t_hwreset();
        t_basic(16'h1234, 16'h8001);
        rst = 1'b1; wclk(3); rst = 1'b0; wclk(HP);
        t_reset();
    endtask

    initial begin
        wclk(4); rst = 1'b0; wclk(HP);
        t_reset();
        t_basic(16'hA5C3, 16'h0F0F);
        t_basic(16'h8001, 16'hFFFF);
        t_basic(16'h0000, 16'h7FFE);
        t_idle();
        t_long(16'h5AA5);
        t_swreset();
        t_hwreset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule